// File: doc/BRIEF.md
# Quadrature One-Bit LO Mixer

This block takes a one-bit comparator stream, sampled once per system clock, and mixes it with two one-bit local oscillators in quadrature. Both oscillators come from 32-bit phase accumulators that share one frequency tuning word. Each oscillator bit is the top bit of its accumulator. Mixing is a bitwise XOR, so no multiplier is needed. The input bits and the two oscillator bit streams are packed into 32-bit words with the oldest sample in the most significant bit. Once per word the block presents an in-phase word (input XOR cosine) and a quadrature word (input XOR sine), with a one-cycle valid strobe.

A tuning word is loaded through a one-cycle load port. Before use, the word is rounded to the nearest multiple of 2^13. This makes the oscillator pattern repeat exactly over a whole number of words. Software picks the tuning word for the centre frequency plus the output sample rate, so the wanted signal lands away from DC. A load also restarts both accumulators at their fixed start phases and restarts word packing, which keeps the two oscillators in exact quadrature.

Top module: `iq_bit_mixer`

## Requirements
- R1: While reset is asserted, `mix_valid` is 0 and both `i_word` and `q_word` are 0.
- R2: On every sample clock each oscillator bit equals bit 31 of its accumulator, and the accumulator then advances by the active step modulo 2^32. After a load the cosine accumulator starts at 0xC0000000 and the sine accumulator starts at 0.
- R3: The active step equals the loaded tuning word rounded to the nearest multiple of 2^13: add 0x1000, clear bits 12:0, and wrap modulo 2^32.
- R4: Sample n of a word (n = 0 first) sits at bit position 31-n of the word.
- R5: `i_word` equals the packed input bits XOR the packed cosine bits, and `q_word` equals the packed input bits XOR the packed sine bits, taken over the same 32 samples.
- R6: `mix_valid` is high for exactly one cycle after every 32nd sample. It is never high on two cycles in a row, and `i_word` and `q_word` hold their values while it is low.
- R7: A cycle with `ftw_load` high is not a sample. It discards any partly packed word, restarts both phases as in R2, and the next `mix_valid` follows the 32nd sample after the load. `mix_valid` is low in the cycle that follows the load.
- R8: After reset the step is 0, with the cosine at 0xC0000000 and the sine at 0. The cosine bit is therefore always 1 and the sine bit always 0, so `i_word` is the inverted input and `q_word` is the input unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one input sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Comparator bit sampled each clock |
| ftw_load | input | 1 | Load strobe for the tuning word; restarts phases and packing |
| ftw_in | input | 32 | Raw frequency tuning word (2^32 * f_LO / f_clk) |
| i_word | output | 32 | In-phase mixed word, oldest sample in bit 31 |
| q_word | output | 32 | Quadrature mixed word, oldest sample in bit 31 |
| mix_valid | output | 1 | One-cycle strobe when a new pair of mixed words is ready |

## Verification
The bench aims at tuning words that sit near the rounding boundary (0x0FFF, 0x1000) and at the wrap at the top of the range (0xFFFFF000). A design that truncates instead of rounding, or that saturates instead of wrapping, produces a different oscillator pattern and therefore wrong mixed words. A load in the middle of a word checks that stale bits are dropped and that the word boundary restarts. A design that keeps its old count emits a strobe too early. A design that does not reset the phases loses the fixed cosine and sine start values and mixes with the wrong pattern. Words built from step 0 and a lone leading one check the bit ordering: a reversed packer places that one at bit 0 instead of bit 31.

// File: rtl/iqmix_pkg.sv
package iqmix_pkg;
   // Start phase of the cosine oscillator: three quarters of a turn.
   function automatic logic [63:0] cos_start(input int unsigned phase_w);
      logic [63:0] v;
      v = 64'd3 << (phase_w - 2);
      return v;
   endfunction

   typedef enum logic [1:0] {
      LANE_RX  = 2'd0,
      LANE_COS = 2'd1,
      LANE_SIN = 2'd2
   } lane_e;

   localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/ftw_align.sv
module ftw_align #(
   parameter int unsigned PHASE_W   = 32,
   parameter int unsigned ALIGN_LSB = 13,
   parameter bit          ALIGN_EN  = 1'b1
) (
   input  logic [PHASE_W-1:0] raw_ftw,
   output logic [PHASE_W-1:0] step_out
);
   generate
      if (ALIGN_EN) begin : g_round
         localparam logic [PHASE_W-1:0] HALF = PHASE_W'(1) << (ALIGN_LSB - 1);
         logic [PHASE_W-1:0] biased;
         always_comb begin
            biased   = raw_ftw + HALF;
            step_out = {biased[PHASE_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
         end
      end else begin : g_pass
         assign step_out = raw_ftw;
      end
   endgenerate
endmodule

// File: rtl/lo_nco.sv
module lo_nco #(
   parameter int unsigned PHASE_W = 32,
   parameter logic [PHASE_W-1:0] START = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [PHASE_W-1:0] step,
   output logic               lo_bit
);
   logic [PHASE_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc <= START;
      end else begin
         acc <= acc + step;
      end
   end

   assign lo_bit = acc[PHASE_W-1];
endmodule

// File: rtl/bit_packer.sv
module bit_packer #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_now
);
   logic [WORD_W-2:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         sr <= '0;
      end else begin
         sr <= {sr[WORD_W-3:0], bit_in};
      end
   end

   // Oldest bit ends up in the MSB once WORD_W samples are in.
   assign word_now = {sr, bit_in};
endmodule

// File: rtl/iq_bit_mixer.sv
module iq_bit_mixer #(
   parameter int unsigned PHASE_W   = 32,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ALIGN_LSB = 13,
   parameter bit          ALIGN_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_bit,
   input  logic               ftw_load,
   input  logic [PHASE_W-1:0] ftw_in,
   output logic [WORD_W-1:0]  i_word,
   output logic [WORD_W-1:0]  q_word,
   output logic               mix_valid
);
   import iqmix_pkg::*;

   localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
   localparam logic [PHASE_W-1:0] COS_START = PHASE_W'(cos_start(PHASE_W));
   localparam logic [PHASE_W-1:0] SIN_START = '0;

   generate
      if (PHASE_W < 4 || PHASE_W > 64) begin : g_bad_phase
         $error("iq_bit_mixer: PHASE_W must be in 4..64");
      end
      if (WORD_W < 3) begin : g_bad_word
         $error("iq_bit_mixer: WORD_W must be at least 3");
      end
      if (ALIGN_EN && (ALIGN_LSB < 1 || ALIGN_LSB >= PHASE_W)) begin : g_bad_align
         $error("iq_bit_mixer: ALIGN_LSB out of range");
      end
   endgenerate

   logic [PHASE_W-1:0] step_next, step_q;
   logic [CNT_W-1:0]   cnt;
   logic               cos_bit, sin_bit;
   logic [NUM_LANES-1:0]           lane_bits;
   logic [WORD_W-1:0]              lane_word [NUM_LANES];
   logic                           word_end;

   ftw_align #(
      .PHASE_W  (PHASE_W),
      .ALIGN_LSB(ALIGN_LSB),
      .ALIGN_EN (ALIGN_EN)
   ) u_align (
      .raw_ftw (ftw_in),
      .step_out(step_next)
   );

   lo_nco #(.PHASE_W(PHASE_W), .START(COS_START)) u_nco_cos (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(ftw_load),
      .step   (step_q),
      .lo_bit (cos_bit)
   );

   lo_nco #(.PHASE_W(PHASE_W), .START(SIN_START)) u_nco_sin (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(ftw_load),
      .step   (step_q),
      .lo_bit (sin_bit)
   );

   always_comb begin
      lane_bits           = '0;
      lane_bits[LANE_RX]  = rx_bit;
      lane_bits[LANE_COS] = cos_bit;
      lane_bits[LANE_SIN] = sin_bit;
   end

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         bit_packer #(.WORD_W(WORD_W)) u_pack (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (ftw_load),
            .bit_in  (lane_bits[g]),
            .word_now(lane_word[g])
         );
      end
   endgenerate

   assign word_end = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q    <= '0;
         cnt       <= '0;
         mix_valid <= 1'b0;
         i_word    <= '0;
         q_word    <= '0;
      end else if (ftw_load) begin
         step_q    <= step_next;
         cnt       <= '0;
         mix_valid <= 1'b0;
      end else begin
         mix_valid <= word_end;
         cnt       <= word_end ? '0 : cnt + 1'b1;
         if (word_end) begin
            i_word <= lane_word[LANE_RX] ^ lane_word[LANE_COS];
            q_word <= lane_word[LANE_RX] ^ lane_word[LANE_SIN];
         end
      end
   end
endmodule

module iqmix_chk #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ftw_load,
   input logic              mix_valid,
   input logic [WORD_W-1:0] i_word,
   input logic [WORD_W-1:0] q_word
);
   localparam int unsigned GAP_W = $clog2(WORD_W + 2) + 1;
   localparam logic [GAP_W-1:0] FULL = GAP_W'(WORD_W);

   // Sample edges since the last load, reset or strobe.
   logic [GAP_W-1:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n || ftw_load) begin
         gap <= '0;
      end else if (mix_valid) begin
         gap <= GAP_W'(1);
      end else if (gap != '1) begin
         gap <= gap + 1'b1;
      end
   end

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |=> !mix_valid);

   p_hold_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_valid |-> ($stable(i_word) && $stable(q_word)));

   p_strobe_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |-> (gap == FULL));

   p_full_gives_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gap == FULL) |-> mix_valid);

   p_quiet_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ftw_load |=> !mix_valid);
endmodule

bind iq_bit_mixer iqmix_chk #(.WORD_W(WORD_W)) u_iqmix_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ftw_load (ftw_load),
   .mix_valid(mix_valid),
   .i_word   (i_word),
   .q_word   (q_word)
);

// File: tb/tb_iq_bit_mixer.sv
module tb_iq_bit_mixer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_bit = 1'b0;
   logic        ftw_load = 1'b0;
   logic [31:0] ftw_in = '0;
   logic [31:0] i_word, q_word;
   logic        mix_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Bench reference state
   logic [31:0] m_step, m_cos, m_sin;

   iq_bit_mixer dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_bit   (rx_bit),
      .ftw_load (ftw_load),
      .ftw_in   (ftw_in),
      .i_word   (i_word),
      .q_word   (q_word),
      .mix_valid(mix_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] round_ftw(input logic [31:0] x);
      logic [31:0] s;
      s = x + 32'h0000_1000;
      return s & 32'hFFFF_E000;
   endfunction

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_restart(input logic [31:0] raw);
      m_step = round_ftw(raw);
      m_cos  = 32'hC000_0000;
      m_sin  = 32'h0;
   endtask

   // Entered at a falling edge; returns at the falling edge after the strobe.
   task automatic run_word(input logic [31:0] data, input string tag);
      logic [31:0] ec, es;
      bit early;
      early = 1'b0;
      for (int j = 0; j < 32; j++) begin
         rx_bit     = data[31-j];
         ec[31-j]   = m_cos[31];
         es[31-j]   = m_sin[31];
         m_cos      = m_cos + m_step;
         m_sin      = m_sin + m_step;
         @(negedge clk);
         if (j < 31 && mix_valid) early = 1'b1;
      end
      check32({tag, " R6 no early strobe"}, {31'd0, early}, 32'd0);
      check32({tag, " R6 strobe"}, {31'd0, mix_valid}, 32'd1);
      check32({tag, " R5 i_word"}, i_word, data ^ ec);
      check32({tag, " R5 q_word"}, q_word, data ^ es);
   endtask

   task automatic load_ftw(input logic [31:0] raw);
      ftw_load = 1'b1;
      ftw_in   = raw;
      @(negedge clk);
      ftw_load = 1'b0;
      model_restart(raw);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check32("R1 valid in reset", {31'd0, mix_valid}, 32'd0);
      check32("R1 i_word in reset", i_word, 32'd0);
      check32("R1 q_word in reset", q_word, 32'd0);

      model_restart(32'd0);
      rst_n = 1'b1;
      // R8 and R4: step 0, one leading sample
      run_word(32'h8000_0000, "R8 R4 lead one");
      check32("R4 msb first", q_word, 32'h8000_0000);
      check32("R8 cos inverted", i_word, 32'h7FFF_FFFF);
      run_word($urandom(), "R8 random");

      // R3 boundary tuning words
      load_ftw(32'h0000_0FFF);
      run_word($urandom(), "R3 round down");
      load_ftw(32'h0000_1000);
      run_word($urandom(), "R3 round up");
      run_word($urandom(), "R3 round up w2");
      load_ftw(32'hFFFF_F000);
      run_word(32'h0000_0000, "R3 wrap to zero");
      check32("R3 wrap cos all ones", i_word, 32'hFFFF_FFFF);
      load_ftw(32'h4000_0000);
      run_word(32'h0000_0000, "R2 quarter step");
      check32("R2 cos pattern", i_word, 32'h9999_9999);
      check32("R2 sin pattern", q_word, 32'h3333_3333);

      // R2 R5 random tuning words, a few words each
      for (int k = 0; k < 8; k++) begin
         load_ftw($urandom());
         for (int w = 0; w < 3; w++) run_word($urandom(), "R2 R5 random");
      end

      // R7 load in the middle of a word
      for (int k = 0; k < 3; k++) begin
         int part;
         part = 1 + int'($urandom_range(29, 0));
         for (int j = 0; j < part; j++) begin
            rx_bit = 1'($urandom());
            @(negedge clk);
         end
         ftw_load = 1'b1;
         ftw_in   = $urandom();
         @(negedge clk);
         ftw_load = 1'b0;
         check32("R7 quiet after load", {31'd0, mix_valid}, 32'd0);
         model_restart(ftw_in);
         run_word($urandom(), "R7 restart");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired R6 actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule